// File: doc/BRIEF.md
# Registered Command Alignment Stage

This block sits between a memory controller and an SDRAM device on the command and address side. It forwards row/column address, bank select, the three active-low command strobes, the per-rank chip selects, clock enable and the byte-mask lanes to the device. A mode input picks between a transparent path, where the device sees the host signals in the same cycle, and a registered path, where every signal is captured on the rising clock edge and reaches the device one clock later.

Because the data lanes are not registered, the host has to know how the extra stage shifts its timing. The block therefore also produces two host-side strobes: one marking the cycle in which the first write beat must be launched, and one marking the cycle in which the first read beat is valid. Both follow the selected mode and the device CAS latency (2 or 3 clocks).

A command is recognised from the host inputs when at least one chip select is low: read is RAS_n high, CAS_n low, WE_n high; write is RAS_n high, CAS_n low, WE_n low.

Top module: `regCmdStage`

## Requirements
- R1: With `regMode` low, every device-side output (address, bank, RAS_n, CAS_n, WE_n, chip selects, CKE, byte mask) equals the matching host input in the same cycle.
- R2: With `regMode` high, every device-side output equals the value the matching host input had in the previous clock cycle.
- R3: A synchronous reset loads the register stage with a no-operation command: address 0, bank 0, RAS_n/CAS_n/WE_n high, all chip selects high, CKE high, byte mask 0; no strobe fires from commands issued before the reset.
- R4: With `regMode` low, `rdValid` is high exactly CL cycles after a read command (CL = 2 when `casLat3` is 0, CL = 3 when it is 1).
- R5: With `regMode` high, `rdValid` is high exactly CL+1 cycles after a read command.
- R6: With `regMode` low, `wrLaunch` is high in the same cycle as a write command.
- R7: With `regMode` high, `wrLaunch` is high exactly one cycle after a write command.
- R8: A read or write pattern presented with all chip selects high is a deselect and produces neither strobe.
- R9: The byte-mask lanes take exactly the same delay as the address in both modes, so a mask value stays aligned with the command it was issued with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| regMode | input | 1 | 0 transparent, 1 one-clock registered |
| casLat3 | input | 1 | Device CAS latency: 0 means 2, 1 means 3 |
| hostAddr | input | ROW_W | Multiplexed row/column address from host |
| hostBank | input | BANK_W | Bank select from host |
| hostRasN | input | 1 | Row strobe, active low |
| hostCasN | input | 1 | Column strobe, active low |
| hostWeN | input | 1 | Write enable, active low |
| hostCsN | input | CS_W | Chip selects, active low |
| hostCke | input | 1 | Clock enable from host |
| hostDqm | input | MASK_W | Byte-mask lanes from host |
| devAddr | output | ROW_W | Address to device |
| devBank | output | BANK_W | Bank select to device |
| devRasN | output | 1 | Row strobe to device |
| devCasN | output | 1 | Column strobe to device |
| devWeN | output | 1 | Write enable to device |
| devCsN | output | CS_W | Chip selects to device |
| devCke | output | 1 | Clock enable to device |
| devDqm | output | MASK_W | Byte mask to device |
| wrLaunch | output | 1 | Host should drive the first write beat now |
| rdValid | output | 1 | First read beat is valid at the host now |

## Verification
The hardest situation to reach is a read whose delay window straddles a change of CAS latency or mode, or a reset that lands while reads are still in flight; a port-level observer must then see the strobe either at the new distance or not at all. The stimulus holds the mode and latency fixed for random-length segments, issues dense random command mixes inside them, switches settings and applies resets between segments without draining, and adds directed deselected reads and writes with every chip select high.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;

  // Controls the control unit hands to the datapath each cycle.
  typedef struct packed {
    logic useReg;  // select registered copy for the device side
    logic clear;   // load the no-operation image into the register
  } stageCtl_t;

  // Strobe delay in clocks for a given mode and latency.
  function automatic int unsigned rdDelay(input logic regMode, input logic casLat3);
    return (casLat3 ? 3 : 2) + (regMode ? 1 : 0);
  endfunction

endpackage

// File: rtl/regcmd_datapath.sv
module regcmd_datapath
  import regcmd_pkg::*;
#(
  parameter int unsigned CMD_W = 31,
  parameter logic [CMD_W-1:0] NOP_IMG = '1
) (
  input  logic             clk,
  input  stageCtl_t        ctl,
  input  logic [CMD_W-1:0] hostCmd,
  output logic [CMD_W-1:0] devCmd
);

  logic [CMD_W-1:0] cmdQ;

  always_ff @(posedge clk) begin
    if (ctl.clear) cmdQ <= NOP_IMG;
    else           cmdQ <= hostCmd;
  end

  assign devCmd = ctl.useReg ? cmdQ : hostCmd;

endmodule

// File: rtl/regcmd_control.sv
module regcmd_control
  import regcmd_pkg::*;
#(
  parameter int unsigned CS_W  = 4,
  parameter int unsigned MAX_CL = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            regMode,
  input  logic            casLat3,
  input  logic            hostRasN,
  input  logic            hostCasN,
  input  logic            hostWeN,
  input  logic [CS_W-1:0] hostCsN,
  output stageCtl_t       ctl,
  output logic            wrLaunch,
  output logic            rdValid
);

  localparam int unsigned PIPE_D = MAX_CL + 1;

  logic selected, isRead, isWrite;
  logic [PIPE_D-1:0] rdPipe;
  logic wrPipe;
  logic [$clog2(PIPE_D)-1:0] rdTap;

  assign selected = ~(&hostCsN);
  assign isRead   = selected & hostRasN & ~hostCasN & hostWeN;
  assign isWrite  = selected & hostRasN & ~hostCasN & ~hostWeN;

  // rdPipe[i] holds a read issued i+1 cycles ago
  always_ff @(posedge clk) begin
    if (rst) begin
      rdPipe <= '0;
      wrPipe <= 1'b0;
    end else begin
      rdPipe <= {rdPipe[PIPE_D-2:0], isRead};
      wrPipe <= isWrite;
    end
  end

  assign rdTap    = ($clog2(PIPE_D))'(rdDelay(regMode, casLat3) - 1);
  assign rdValid  = rdPipe[rdTap];
  assign wrLaunch = regMode ? wrPipe : isWrite;

  assign ctl.useReg = regMode;
  assign ctl.clear  = rst;

endmodule

// File: rtl/regCmdStage.sv
module regCmdStage
  import regcmd_pkg::*;
#(
  parameter int unsigned ROW_W  = 13,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned CS_W   = 4,
  parameter int unsigned MASK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regMode,
  input  logic              casLat3,
  input  logic [ROW_W-1:0]  hostAddr,
  input  logic [BANK_W-1:0] hostBank,
  input  logic              hostRasN,
  input  logic              hostCasN,
  input  logic              hostWeN,
  input  logic [CS_W-1:0]   hostCsN,
  input  logic              hostCke,
  input  logic [MASK_W-1:0] hostDqm,
  output logic [ROW_W-1:0]  devAddr,
  output logic [BANK_W-1:0] devBank,
  output logic              devRasN,
  output logic              devCasN,
  output logic              devWeN,
  output logic [CS_W-1:0]   devCsN,
  output logic              devCke,
  output logic [MASK_W-1:0] devDqm,
  output logic              wrLaunch,
  output logic              rdValid
);

  localparam int unsigned CMD_W = ROW_W + BANK_W + 3 + CS_W + 1 + MASK_W;
  localparam logic [CMD_W-1:0] NOP_IMG =
    {{ROW_W{1'b0}}, {BANK_W{1'b0}}, 3'b111, {CS_W{1'b1}}, 1'b1, {MASK_W{1'b0}}};

  stageCtl_t ctl;
  logic [CMD_W-1:0] hostCmd, devCmd;

  assign hostCmd = {hostAddr, hostBank, hostRasN, hostCasN, hostWeN, hostCsN, hostCke, hostDqm};
  assign {devAddr, devBank, devRasN, devCasN, devWeN, devCsN, devCke, devDqm} = devCmd;

  regcmd_control #(.CS_W(CS_W), .MAX_CL(3)) i_control (
    .clk(clk), .rst(rst), .regMode(regMode), .casLat3(casLat3),
    .hostRasN(hostRasN), .hostCasN(hostCasN), .hostWeN(hostWeN), .hostCsN(hostCsN),
    .ctl(ctl), .wrLaunch(wrLaunch), .rdValid(rdValid)
  );

  regcmd_datapath #(.CMD_W(CMD_W), .NOP_IMG(NOP_IMG)) i_datapath (
    .clk(clk), .ctl(ctl), .hostCmd(hostCmd), .devCmd(devCmd)
  );

endmodule

// File: rtl/regCmdStage_chk.sv
module regCmdStage_chk #(
  parameter int unsigned ROW_W  = 13,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned CS_W   = 4,
  parameter int unsigned MASK_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              regMode,
  input logic              casLat3,
  input logic [ROW_W-1:0]  hostAddr,
  input logic [BANK_W-1:0] hostBank,
  input logic              hostRasN,
  input logic              hostCasN,
  input logic              hostWeN,
  input logic [CS_W-1:0]   hostCsN,
  input logic              hostCke,
  input logic [MASK_W-1:0] hostDqm,
  input logic [ROW_W-1:0]  devAddr,
  input logic [BANK_W-1:0] devBank,
  input logic              devRasN,
  input logic              devCasN,
  input logic              devWeN,
  input logic [CS_W-1:0]   devCsN,
  input logic              devCke,
  input logic [MASK_W-1:0] devDqm,
  input logic              wrLaunch,
  input logic              rdValid
);

  logic chkRd, chkWr, chkSel;
  logic [2:0] sinceRst;

  assign chkSel = |(~hostCsN);
  assign chkRd  = chkSel && hostRasN && !hostCasN && hostWeN;
  assign chkWr  = chkSel && hostRasN && !hostCasN && !hostWeN;

  always_ff @(posedge clk) begin
    if (rst) sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst)
    !regMode |-> (devAddr == hostAddr && devCsN == hostCsN && devDqm == hostDqm)); // R1

  AST_REG_DELAY: assert property (@(posedge clk) disable iff (rst)
    (regMode && sinceRst >= 3'd1) |-> (devAddr == $past(hostAddr) && devCsN == $past(hostCsN))); // R2

  AST_MASK_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (regMode && sinceRst >= 3'd1) |-> (devDqm == $past(hostDqm) && devBank == $past(hostBank))); // R9

  AST_RESET_NOP: assert property (@(posedge clk) disable iff (rst)
    (regMode && sinceRst == 3'd0) |-> (&devCsN && devRasN && devCasN && devWeN)); // R3

  AST_WR_NOW: assert property (@(posedge clk) disable iff (rst)
    !regMode |-> (wrLaunch == chkWr)); // R6

  AST_WR_LATE: assert property (@(posedge clk) disable iff (rst)
    (regMode && sinceRst >= 3'd1 && $past(chkWr)) |-> wrLaunch); // R7

  AST_RD_CL2_THRU: assert property (@(posedge clk) disable iff (rst)
    (!regMode && !casLat3 && sinceRst >= 3'd2 && $past(chkRd, 2)) |-> rdValid); // R4

  AST_RD_CL3_REG: assert property (@(posedge clk) disable iff (rst)
    (regMode && casLat3 && sinceRst >= 3'd4 && $past(chkRd, 4)) |-> rdValid); // R5

  AST_DESELECT: assert property (@(posedge clk) disable iff (rst)
    (!regMode && &hostCsN) |-> !wrLaunch); // R8

endmodule

bind regCmdStage regCmdStage_chk #(
  .ROW_W(ROW_W), .BANK_W(BANK_W), .CS_W(CS_W), .MASK_W(MASK_W)
) i_chk (.*);

// File: tb/test_regCmdStage.sv
module test_regCmdStage;

  localparam int ROW_W = 13, BANK_W = 2, CS_W = 4, MASK_W = 8;
  localparam int CMD_W = ROW_W + BANK_W + 3 + CS_W + 1 + MASK_W;
  localparam logic [CMD_W-1:0] NOP =
    {{ROW_W{1'b0}}, {BANK_W{1'b0}}, 3'b111, {CS_W{1'b1}}, 1'b1, {MASK_W{1'b0}}};

  logic clk = 1'b0, rst = 1'b1, regMode = 1'b0, casLat3 = 1'b0;
  logic [ROW_W-1:0] hostAddr = '0;
  logic [BANK_W-1:0] hostBank = '0;
  logic hostRasN = 1'b1, hostCasN = 1'b1, hostWeN = 1'b1;
  logic [CS_W-1:0] hostCsN = '1;
  logic hostCke = 1'b1;
  logic [MASK_W-1:0] hostDqm = '0;
  logic [ROW_W-1:0] devAddr;
  logic [BANK_W-1:0] devBank;
  logic devRasN, devCasN, devWeN, devCke, wrLaunch, rdValid;
  logic [CS_W-1:0] devCsN;
  logic [MASK_W-1:0] devDqm;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [CMD_W-1:0] histCmd [0:4];
  logic histRd [0:4];
  logic histWr [0:4];

  always #2.5 clk = ~clk;

  regCmdStage i_regCmdStage (.*);

  function automatic logic decRd(input logic [CMD_W-1:0] c);
    logic [CS_W-1:0] cs = c[MASK_W+1 +: CS_W];
    logic [2:0] rcw = c[MASK_W+1+CS_W +: 3];
    return !(&cs) && rcw == 3'b101;
  endfunction

  function automatic logic decWr(input logic [CMD_W-1:0] c);
    logic [CS_W-1:0] cs = c[MASK_W+1 +: CS_W];
    logic [2:0] rcw = c[MASK_W+1+CS_W +: 3];
    return !(&cs) && rcw == 3'b100;
  endfunction

  function automatic logic [CMD_W-1:0] curCmd();
    return {hostAddr, hostBank, hostRasN, hostCasN, hostWeN, hostCsN, hostCke, hostDqm};
  endfunction

  task automatic check(input string req, input logic [CMD_W-1:0] act, input logic [CMD_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clearHist();
    for (int i = 0; i < 5; i++) begin
      histCmd[i] = NOP; histRd[i] = 1'b0; histWr[i] = 1'b0;
    end
  endtask

  task automatic setCmd(input logic [CMD_W-1:0] c);
    {hostAddr, hostBank, hostRasN, hostCasN, hostWeN, hostCsN, hostCke, hostDqm} = c;
  endtask

  // one cycle: drive at negedge, check before the next rising edge, then record
  task automatic step(input logic [CMD_W-1:0] c, input logic doRst);
    logic [CMD_W-1:0] devNow, expDev;
    int n;
    @(negedge clk);
    setCmd(c);
    rst = doRst;
    #1;
    if (!doRst) begin
      devNow = {devAddr, devBank, devRasN, devCasN, devWeN, devCsN, devCke, devDqm};
      expDev = regMode ? histCmd[0] : c;
      check(regMode ? "R2/R9 registered path" : "R1/R9 transparent path", devNow, expDev);
      n = (casLat3 ? 3 : 2) + (regMode ? 1 : 0);
      check(regMode ? "R5 read valid CL+1" : "R4 read valid CL",
            CMD_W'(rdValid), CMD_W'(histRd[n-1]));
      check(regMode ? "R7 write launch +1" : "R6 write launch now",
            CMD_W'(wrLaunch), CMD_W'(regMode ? histWr[0] : decWr(c)));
    end
    @(posedge clk);
    if (doRst) clearHist();
    else begin
      for (int i = 4; i > 0; i--) begin
        histCmd[i] = histCmd[i-1]; histRd[i] = histRd[i-1]; histWr[i] = histWr[i-1];
      end
      histCmd[0] = c; histRd[0] = decRd(c); histWr[0] = decWr(c);
    end
  endtask

  function automatic logic [CMD_W-1:0] randCmd();
    logic [CMD_W-1:0] c;
    int k = $urandom_range(0, 9);
    logic [CS_W-1:0] cs;
    logic [2:0] rcw;
    cs = CS_W'($urandom);
    if (k < 3) rcw = 3'b101;
    else if (k < 6) rcw = 3'b100;
    else rcw = 3'($urandom);
    c = {ROW_W'($urandom), BANK_W'($urandom), rcw, cs, 1'($urandom), MASK_W'($urandom)};
    return c;
  endfunction

  function automatic logic [CMD_W-1:0] mk(input logic [2:0] rcw, input logic [CS_W-1:0] cs,
                                          input logic [ROW_W-1:0] a, input logic [MASK_W-1:0] m);
    return {a, BANK_W'(2'b10), rcw, cs, 1'b1, m};
  endfunction

  initial begin
    process::self().srandom(32'h5eed_0042);
    void'($urandom(32'h5eed_0042));
    clearHist();
    // R3: reset then registered mode shows the no-op image
    regMode = 1'b1;
    step(NOP, 1'b1);
    step(NOP, 1'b1);
    @(negedge clk); rst = 1'b0; #1;
    check("R3 reset image", {devAddr, devBank, devRasN, devCasN, devWeN, devCsN, devCke, devDqm}, NOP);
    check("R3 no read strobe after reset", CMD_W'(rdValid), '0);
    @(posedge clk);

    // directed: reads in each mode/latency, back to back
    for (int m = 0; m < 4; m++) begin
      regMode = m[1]; casLat3 = m[0];
      step(mk(3'b101, 4'b1110, 13'h1abc, 8'h0f), 1'b0);
      step(mk(3'b100, 4'b1101, 13'h0123, 8'hf0), 1'b0);
      step(mk(3'b101, 4'b0111, 13'h1fff, 8'haa), 1'b0);
      for (int i = 0; i < 5; i++) step(NOP, 1'b0);
    end

    // R8: deselected read and write patterns
    for (int m = 0; m < 2; m++) begin
      regMode = m[0]; casLat3 = 1'b1;
      step(mk(3'b100, '1, 13'h0555, 8'h55), 1'b0);
      step(mk(3'b101, '1, 13'h0aaa, 8'h33), 1'b0);
      for (int i = 0; i < 5; i++) step(NOP, 1'b0);
    end

    // reset with reads in flight (R3)
    regMode = 1'b1; casLat3 = 1'b1;
    step(mk(3'b101, 4'b1110, 13'h0001, 8'h01), 1'b0);
    step(mk(3'b101, 4'b1110, 13'h0002, 8'h02), 1'b0);
    step(NOP, 1'b1);
    for (int i = 0; i < 6; i++) step(NOP, 1'b0);

    // random segments, settings changed without draining
    for (int s = 0; s < 60; s++) begin
      regMode = 1'($urandom); casLat3 = 1'($urandom);
      for (int i = 0; i < $urandom_range(5, 40); i++) step(randCmd(), 1'b0);
      if ($urandom_range(0, 9) == 0) step(NOP, 1'b1);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule